// File: doc/BRIEF.md
# Predicate-Aware Dispatch Stage

This block is the dispatch stage of a small VLIW pipeline. It sits directly after fetch, ahead of decode, register read, execute and write-back. It reads the predicate register file early, while the bundle is still in dispatch. Because of this, a fetched bundle can carry more operations than there are functional units, as long as the operations that share a unit are guarded by predicates that cannot both be true. Each cycle it takes one bundle of `FW` operation lanes. It evaluates every guard against the predicate file and drops operations whose guard is false. It then routes the surviving operations to `NFU` functional-unit slots, and those slot outputs feed decode on the next cycle.

The block owns the predicate register file. A predicate-define operation in a bundle evaluates one condition bit and writes a complementary pair of predicates: one register gets the condition and the other gets its inverse. Predicate-define operations are handled entirely inside the stage and never take a functional-unit slot. If an ordinary operation in the same bundle is guarded by a predicate that a predicate-define in that bundle writes, the stage asks upstream to hold the bundle for exactly one cycle. During that cycle the new value is committed. On the repeated presentation the bundle is dispatched against the updated file, and its predicate-define operations are not applied a second time.

Top module: `pdp_dispatch`

## Requirements
- R1: After reset every predicate register reads false except register 0, which reads true; `slot_valid_o` is all zero, `multi_true_o` is low and `stall_o` is low.
- R2: An ordinary operation guarded by predicate index 0 is always dispatched to the slot named by its `op_slot_i` field.
- R3: An ordinary operation whose guard predicate is false produces no slot output.
- R4: Several ordinary operations may name the same slot. The one whose guard is true appears on that slot on the cycle after the accepting edge, with its `op_word_i` on `slot_word_o` and its lane number on `slot_src_o`.
- R5: If two or more ordinary operations with true guards name the same slot in one accepted bundle, the lowest-numbered lane is issued and `multi_true_o` is high on the same cycle as that slot output.
- R6: A predicate-define operation (`op_is_pdef_i` = 1) with a true guard writes `op_cond_i` to predicate `op_pdst_t_i` and its inverse to `op_pdst_f_i` at the end of the cycle. The next bundle sees the new values without a stall. If its guard is false it writes nothing. It never produces a slot output. Within one bundle the lanes are applied in ascending order, with the true-destination write before the false-destination write, so the last write wins.
- R7: If an ordinary operation with a nonzero guard index uses a predicate that a valid predicate-define in the same bundle writes, `stall_o` is high for exactly one cycle and no slot is issued for that cycle. On the next cycle the held bundle is dispatched using the updated predicates.
- R8: A write by a predicate-define to predicate index 0 is ignored, and register 0 stays true.
- R9: When `bnd_valid_i` is low, nothing is dispatched on the following cycle and no predicate changes, whatever the lane inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_valid_i | input | 1 | A bundle is present on the lane inputs |
| op_valid_i | input | FW | Per-lane operation present |
| op_is_pdef_i | input | FW | Per-lane: operation is a predicate-define |
| op_cond_i | input | FW | Per-lane condition bit for predicate-define |
| op_guard_i | input | FW*PW | Per-lane guard predicate index |
| op_pdst_t_i | input | FW*PW | Per-lane predicate that receives the condition |
| op_pdst_f_i | input | FW*PW | Per-lane predicate that receives the inverse |
| op_slot_i | input | FW*SW | Per-lane target functional-unit slot |
| op_word_i | input | FW*OPW | Per-lane operation payload |
| stall_o | output | 1 | Hold the current bundle for one more cycle |
| slot_valid_o | output | NFU | Slot carries an issued operation |
| slot_word_o | output | NFU*OPW | Payload per slot |
| slot_src_o | output | NFU*IW | Originating lane per slot |
| multi_true_o | output | 1 | More than one true-guarded operation collided on a slot |

## Verification
`stall_o` is combinational, so it is due in the same cycle the bundle is presented; the bench samples it 1 ns after driving the inputs. Slot outputs, `multi_true_o` and predicate updates appear one clock after the edge that accepts the bundle. The bench's behavioural model advances at that edge and compares the registered outputs 1 ns after it. Predicate contents are observed indirectly: later bundles guard operations on the registers in question, so a wrong or missing write shows up as a wrong slot output one cycle after that later bundle.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

    // dispatch phase of the bundle currently on the inputs
    typedef enum logic {
        PH_FIRST  = 1'b0,   // first presentation, predicate-defines commit here
        PH_REPLAY = 1'b1    // held bundle after an interlock cycle
    } phase_e;

endpackage

// File: rtl/pdp_predfile.sv
module pdp_predfile #(
    parameter int NPRED = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPRED-1:0] we_i,
    input  logic [NPRED-1:0] wd_i,
    output logic [NPRED-1:0] pred_o
);

    logic [NPRED-1:0] pred_d, pred_q;

    always_comb begin
        pred_d = pred_q;
        for (int k = 1; k < NPRED; k++) begin
            if (we_i[k]) pred_d[k] = wd_i[k];
        end
        pred_d[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pred_q <= NPRED'(1);
        else        pred_q <= pred_d;
    end

    assign pred_o = {pred_q[NPRED-1:1], 1'b1};

    // R6
    pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|we_i) |=> $stable(pred_o));

endmodule

// File: rtl/pdp_hazard.sv
module pdp_hazard #(
    parameter int FW = 4,
    parameter int PW = 3
) (
    input  logic [FW-1:0]         op_valid_i,
    input  logic [FW-1:0]         op_is_pdef_i,
    input  logic [FW-1:0][PW-1:0] op_guard_i,
    input  logic [FW-1:0][PW-1:0] op_pdst_t_i,
    input  logic [FW-1:0][PW-1:0] op_pdst_f_i,
    output logic                  hazard_o
);

    always_comb begin
        hazard_o = 1'b0;
        for (int c = 0; c < FW; c++) begin
            for (int p = 0; p < FW; p++) begin
                if (op_valid_i[c] && !op_is_pdef_i[c] && (op_guard_i[c] != '0) &&
                    op_valid_i[p] && op_is_pdef_i[p] &&
                    ((op_guard_i[c] == op_pdst_t_i[p]) || (op_guard_i[c] == op_pdst_f_i[p])))
                    hazard_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pdp_slot_arb.sv
module pdp_slot_arb #(
    parameter int FW = 4,
    parameter int IW = 2
) (
    input  logic [FW-1:0] cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic          multi_o
);

    always_comb begin
        idx_o = '0;
        for (int k = FW - 1; k >= 0; k--) begin
            if (cand_i[k]) idx_o = IW'(k);
        end
        any_o   = |cand_i;
        multi_o = ($countones(cand_i) > 1);
    end

endmodule

// File: rtl/pdp_dispatch.sv
module pdp_dispatch
    import pdp_pkg::*;
#(
    parameter int FW    = 4,
    parameter int NFU   = 2,
    parameter int NPRED = 8,
    parameter int OPW   = 8,
    localparam int PW   = $clog2(NPRED),
    localparam int SW   = (NFU > 1) ? $clog2(NFU) : 1,
    localparam int IW   = (FW > 1) ? $clog2(FW) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bnd_valid_i,
    input  logic [FW-1:0]          op_valid_i,
    input  logic [FW-1:0]          op_is_pdef_i,
    input  logic [FW-1:0]          op_cond_i,
    input  logic [FW-1:0][PW-1:0]  op_guard_i,
    input  logic [FW-1:0][PW-1:0]  op_pdst_t_i,
    input  logic [FW-1:0][PW-1:0]  op_pdst_f_i,
    input  logic [FW-1:0][SW-1:0]  op_slot_i,
    input  logic [FW-1:0][OPW-1:0] op_word_i,
    output logic                   stall_o,
    output logic [NFU-1:0]         slot_valid_o,
    output logic [NFU-1:0][OPW-1:0] slot_word_o,
    output logic [NFU-1:0][IW-1:0] slot_src_o,
    output logic                   multi_true_o
);

    typedef struct packed {
        phase_e                   phase;
        logic [NFU-1:0]           vld;
        logic [NFU-1:0][OPW-1:0]  word;
        logic [NFU-1:0][IW-1:0]   src;
        logic                     multi;
    } state_t;

    state_t st_d, st_q;

    logic [NPRED-1:0]        pred;
    logic [NPRED-1:0]        pwe, pwd;
    logic [FW-1:0]           guard_true;
    logic                    hazard;
    logic                    accept;
    logic [NFU-1:0][FW-1:0]  cand;
    logic [NFU-1:0]          arb_any, arb_multi;
    logic [NFU-1:0][IW-1:0]  arb_idx;

    pdp_predfile #(.NPRED(NPRED)) u_pfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (pwe),
        .wd_i   (pwd),
        .pred_o (pred)
    );

    pdp_hazard #(.FW(FW), .PW(PW)) u_haz (
        .op_valid_i   (op_valid_i),
        .op_is_pdef_i (op_is_pdef_i),
        .op_guard_i   (op_guard_i),
        .op_pdst_t_i  (op_pdst_t_i),
        .op_pdst_f_i  (op_pdst_f_i),
        .hazard_o     (hazard)
    );

    for (genvar l = 0; l < FW; l++) begin : g_guard
        assign guard_true[l] = pred[op_guard_i[l]];
    end

    assign stall_o = bnd_valid_i && (st_q.phase == PH_FIRST) && hazard;
    assign accept  = bnd_valid_i && !stall_o;

    // predicate-define writes, applied once per bundle on its first cycle
    always_comb begin
        pwe = '0;
        pwd = '0;
        if (bnd_valid_i && (st_q.phase == PH_FIRST)) begin
            for (int l = 0; l < FW; l++) begin
                if (op_valid_i[l] && op_is_pdef_i[l] && guard_true[l]) begin
                    pwe[op_pdst_t_i[l]] = 1'b1;
                    pwd[op_pdst_t_i[l]] = op_cond_i[l];
                    pwe[op_pdst_f_i[l]] = 1'b1;
                    pwd[op_pdst_f_i[l]] = !op_cond_i[l];
                end
            end
        end
    end

    for (genvar s = 0; s < NFU; s++) begin : g_slot
        for (genvar l = 0; l < FW; l++) begin : g_lane
            assign cand[s][l] = accept && op_valid_i[l] && !op_is_pdef_i[l] &&
                                guard_true[l] && (op_slot_i[l] == SW'(s));
        end
        pdp_slot_arb #(.FW(FW), .IW(IW)) u_arb (
            .cand_i  (cand[s]),
            .any_o   (arb_any[s]),
            .idx_o   (arb_idx[s]),
            .multi_o (arb_multi[s])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.phase = stall_o ? PH_REPLAY : PH_FIRST;
        st_d.multi = |arb_multi;
        for (int s = 0; s < NFU; s++) begin
            st_d.vld[s]  = arb_any[s];
            st_d.src[s]  = arb_any[s] ? arb_idx[s] : '0;
            st_d.word[s] = arb_any[s] ? op_word_i[arb_idx[s]] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_FIRST, vld: '0, word: '0, src: '0, multi: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_valid_o = st_q.vld;
    assign slot_word_o  = st_q.word;
    assign slot_src_o   = st_q.src;
    assign multi_true_o = st_q.multi;

    // R7
    single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !stall_o);

    // R7
    stall_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> (slot_valid_o == '0));

    // R5
    multi_with_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_true_o |-> (|slot_valid_o));

    // R9
    idle_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd_valid_i |=> ((slot_valid_o == '0) && !multi_true_o));

endmodule

// File: tb/test_pdp_dispatch.sv
module test_pdp_dispatch;

    localparam int FW = 4, NFU = 2, NPRED = 8, OPW = 8;
    localparam int PW = 3, SW = 1, IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bnd_valid;
    logic [FW-1:0] vld, pdef, cond;
    logic [FW-1:0][PW-1:0] grd, dt, df;
    logic [FW-1:0][SW-1:0] slt;
    logic [FW-1:0][OPW-1:0] wrd;
    logic stall;
    logic [NFU-1:0] s_vld;
    logic [NFU-1:0][OPW-1:0] s_word;
    logic [NFU-1:0][IW-1:0] s_src;
    logic multi;

    int total = 0, bad = 0;
    bit done = 0;

    // model state
    bit [NPRED-1:0] mp;
    bit mrep;
    bit e_vld [NFU];
    int e_word [NFU];
    int e_src [NFU];
    bit e_multi;
    bit last_stall;

    always #4 clk = ~clk;

    pdp_dispatch #(.FW(FW), .NFU(NFU), .NPRED(NPRED), .OPW(OPW)) i_pdp_dispatch (
        .clk(clk), .rst_n(rst_n), .bnd_valid_i(bnd_valid),
        .op_valid_i(vld), .op_is_pdef_i(pdef), .op_cond_i(cond),
        .op_guard_i(grd), .op_pdst_t_i(dt), .op_pdst_f_i(df),
        .op_slot_i(slt), .op_word_i(wrd),
        .stall_o(stall), .slot_valid_o(s_vld), .slot_word_o(s_word),
        .slot_src_o(s_src), .multi_true_o(multi)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clr();
        bnd_valid = 1'b0; vld = '0; pdef = '0; cond = '0;
        grd = '0; dt = '0; df = '0; slt = '0; wrd = '0;
    endtask

    task automatic set_op(input int l, input int g, input int s, input int w);
        vld[l] = 1'b1; pdef[l] = 1'b0; grd[l] = PW'(g); slt[l] = SW'(s); wrd[l] = OPW'(w);
    endtask

    task automatic set_pdef(input int l, input int g, input int t, input int f, input bit c);
        vld[l] = 1'b1; pdef[l] = 1'b1; grd[l] = PW'(g); dt[l] = PW'(t); df[l] = PW'(f);
        cond[l] = c; slt[l] = SW'(l); wrd[l] = OPW'(8'hE0 + l);
    endtask

    // one clock: model the presented bundle, compare stall now and outputs after the edge
    task automatic one_cycle(input string tag);
        bit haz, mstall, macc;
        bit [NPRED-1:0] mp_n;
        int cnt;
        #1;
        haz = 0;
        for (int c = 0; c < FW; c++)
            for (int p = 0; p < FW; p++)
                if (vld[c] && !pdef[c] && grd[c] != 0 && vld[p] && pdef[p] &&
                    (grd[c] == dt[p] || grd[c] == df[p])) haz = 1;
        mstall = bnd_valid && !mrep && haz;
        macc = bnd_valid && !mstall;
        check(stall == mstall, tag, "stall", int'(stall), int'(mstall));
        e_multi = 0;
        for (int s = 0; s < NFU; s++) begin
            cnt = 0; e_vld[s] = 0; e_word[s] = 0; e_src[s] = 0;
            for (int l = 0; l < FW; l++)
                if (macc && vld[l] && !pdef[l] && mp[grd[l]] && int'(slt[l]) == s) begin
                    cnt++;
                    if (cnt == 1) begin e_vld[s] = 1; e_word[s] = int'(wrd[l]); e_src[s] = l; end
                end
            if (cnt > 1) e_multi = 1;
        end
        mp_n = mp;
        if (bnd_valid && !mrep)
            for (int l = 0; l < FW; l++)
                if (vld[l] && pdef[l] && mp[grd[l]]) begin
                    mp_n[dt[l]] = cond[l];
                    mp_n[df[l]] = !cond[l];
                end
        mp_n[0] = 1'b1;
        @(posedge clk);
        #1;
        mp = mp_n;
        mrep = mstall;
        last_stall = mstall;
        for (int s = 0; s < NFU; s++) begin
            check(s_vld[s] == e_vld[s], tag, $sformatf("slot%0d valid", s), int'(s_vld[s]), int'(e_vld[s]));
            if (e_vld[s]) begin
                check(int'(s_word[s]) == e_word[s], tag, $sformatf("slot%0d word", s), int'(s_word[s]), e_word[s]);
                check(int'(s_src[s]) == e_src[s], tag, $sformatf("slot%0d src", s), int'(s_src[s]), e_src[s]);
            end
        end
        check(multi == e_multi, tag, "multi", int'(multi), int'(e_multi));
        @(negedge clk);
    endtask

    // present a bundle until accepted
    task automatic run(input string tag);
        one_cycle(tag);
        if (last_stall) one_cycle(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clr();
        mp = NPRED'(1); mrep = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state at the ports
        check(s_vld == '0, "R1", "reset valid", int'(s_vld), 0);
        check(multi == 1'b0, "R1", "reset multi", int'(multi), 0);
        check(stall == 1'b0, "R1", "reset stall", int'(stall), 0);
        @(negedge clk);
        // R1 predicates start false: p1..p7 guarded ops do not issue
        clr(); bnd_valid = 1; set_op(0, 1, 0, 8'h11); set_op(1, 7, 1, 8'h17); run("R1");
        // R2 constant-true guard
        clr(); bnd_valid = 1; set_op(0, 0, 0, 8'hA5); set_op(1, 0, 1, 8'h3C); run("R2");
        // R6 define p1=1 p2=0
        clr(); bnd_valid = 1; set_pdef(0, 0, 1, 2, 1); set_op(1, 0, 1, 8'h42); run("R6");
        // R4 / R3 disjoint ops sharing slot 0
        clr(); bnd_valid = 1; set_op(0, 1, 0, 8'h21); set_op(1, 2, 0, 8'h22); set_op(2, 2, 1, 8'h23); run("R4");
        // R6 flip condition
        clr(); bnd_valid = 1; set_pdef(3, 0, 1, 2, 0); run("R6");
        clr(); bnd_valid = 1; set_op(0, 1, 0, 8'h31); set_op(3, 2, 0, 8'h34); run("R3");
        // R5 collision on slot 1
        clr(); bnd_valid = 1; set_op(1, 2, 1, 8'h51); set_op(0, 0, 1, 8'h50); set_op(3, 0, 1, 8'h53); run("R5");
        // R7 same-bundle consumer interlock
        clr(); bnd_valid = 1; set_pdef(0, 0, 3, 4, 1); set_op(1, 3, 0, 8'h71); set_op(2, 4, 1, 8'h72); run("R7");
        // R8 write to p0 ignored
        clr(); bnd_valid = 1; set_pdef(2, 0, 0, 5, 0); run("R8");
        clr(); bnd_valid = 1; set_op(0, 0, 0, 8'h80); set_op(1, 5, 1, 8'h85); run("R8");
        // R6 predicate-define with false guard writes nothing
        clr(); bnd_valid = 1; set_pdef(0, 6, 7, 6, 1); run("R6");
        clr(); bnd_valid = 1; set_op(0, 7, 0, 8'h67); run("R6");
        // R9 invalid bundle
        clr(); set_op(0, 0, 0, 8'h90); set_pdef(1, 0, 6, 7, 1); run("R9");
        clr(); bnd_valid = 1; set_op(0, 6, 0, 8'h96); set_op(1, 7, 1, 8'h97); run("R9");
        // mixed traffic
        for (int n = 0; n < 300; n++) begin
            clr();
            bnd_valid = ($urandom_range(0, 7) != 0);
            for (int l = 0; l < FW; l++) begin
                if ($urandom_range(0, 3) != 0) begin
                    if ($urandom_range(0, 3) == 0)
                        set_pdef(l, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7), 1'($urandom_range(0, 1)));
                    else
                        set_op(l, $urandom_range(0, 7), $urandom_range(0, 1), $urandom_range(0, 255));
                end
            end
            run("R4");
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule